// File: doc/BRIEF.md
# Ethernet Receive Destination-Address Filter

This block sits at the front of a receive path and decides, per incoming frame, whether the frame should be kept. It watches the first six bytes of the frame (the destination address), presented one byte per valid cycle with a strobe on the first byte. From those six bytes it forms a unicast, multicast or broadcast class. It computes a 32-bit checksum of the address a nibble at a time and uses six of its bits to pick one entry of a 64-entry hash table. It also compares the address with a programmed station address.

Six enable bits select which matching methods may accept the frame. The accept decision is the OR of the enabled methods that match. A global pass-all input overrides the result. A cause vector shows which methods matched. The same causes feed sticky wake-up status bits, and each of those bits is cleared by a one on its clear input. Payload and frame check sequence handling lie outside the block.

Top module: `rx_addr_filter`

## Requirements
- R1: While reset is asserted and after it is released, dec_vld_o, accept_o, bcast_o, mcast_o, cause_o and wake_stat_o are all 0.
- R2: A byte is taken on a clock edge where byte_vld_i is 1. When sof_i is 1 with byte_vld_i, that byte is address byte 0, even in the middle of an earlier address. The following five taken bytes are bytes 1 to 5, and idle cycles between them are allowed. Bytes taken after byte 5 and before the next sof_i are ignored and produce no decision.
- R3: dec_vld_o is 1 for exactly the one cycle after the edge that takes byte 5. accept_o, bcast_o, mcast_o and cause_o change only at that edge and hold their values until the next decision.
- R4: mcast_o is bit 0 of address byte 0. bcast_o is 1 only when all six bytes are 0xFF. A broadcast address also counts as multicast, and any non-multicast address is unicast.
- R5: The station address is packed as sta_w2_i = {byte1, byte0}, sta_w1_i = {byte3, byte2}, sta_w0_i = {byte5, byte4}, with the lower-numbered byte in bits [7:0]. With filt_en_i[5] set, an exact match sets cause bit 5.
- R6: With filt_en_i[1] set, a broadcast address sets cause bit 1.
- R7: With filt_en_i[0] set, any unicast address sets cause bit 0. With filt_en_i[2] set, any multicast address sets cause bit 2.
- R8: The hash register starts at 0xFFFFFFFF. For each byte, the low nibble is processed and then the high nibble. For each nibble n, the old register c gives c' = (c<<4) xor (P<<k) for each k in 0..3 where c[28+k] xor n[3-k] is 1, with P = 0x04C11DB7. No final inversion is applied. The index is c[28:23] after byte 5. Indices 0..31 select hash_lo_i[index] and 32..63 select hash_hi_i[index-32]. A selected 1 sets cause bit 3 for a unicast address when filt_en_i[3] is set, and cause bit 4 for a multicast address when filt_en_i[4] is set.
- R9: cause_o bit k is 1 only if filt_en_i[k] was 1. When pass_all_i is 0, accept_o equals the OR of cause_o.
- R10: pass_all_i set on the byte-5 edge makes accept_o 1 whatever the cause bits are.
- R11: On a decision, each set cause bit sets the matching wake_stat_o bit. A 1 on wake_clr_i[k] clears bit k at the next edge. When a set and a clear hit the same bit on the same edge, the set wins.
- R12: filt_en_i, pass_all_i, the station words and the hash tables are sampled only on the edge that takes byte 5. Their values during bytes 0 to 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Marks the first address byte (qualified by byte_vld_i) |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Receive byte |
| filt_en_i | input | 6 | Method enables: 0 all-unicast, 1 broadcast, 2 all-multicast, 3 unicast hash, 4 multicast hash, 5 station match |
| pass_all_i | input | 1 | Accept every frame |
| sta_w0_i | input | 16 | Station bytes 5 (high) and 4 (low) |
| sta_w1_i | input | 16 | Station bytes 3 (high) and 2 (low) |
| sta_w2_i | input | 16 | Station bytes 1 (high) and 0 (low) |
| hash_lo_i | input | 32 | Hash table entries 0..31 |
| hash_hi_i | input | 32 | Hash table entries 32..63 |
| wake_clr_i | input | 6 | Clear strobes for wake status bits |
| dec_vld_o | output | 1 | Decision pulse |
| accept_o | output | 1 | Frame accepted |
| bcast_o | output | 1 | Address is broadcast |
| mcast_o | output | 1 | Address is multicast |
| cause_o | output | 6 | Matching enabled methods, same bit order as filt_en_i |
| wake_stat_o | output | 6 | Sticky wake-up cause status |

## Verification
The assertions assume that sof_i is only meaningful with byte_vld_i. They also assume the configuration inputs seen on the byte-5 edge are the ones the decision should reflect, which is why they compare results against the one-cycle-delayed enables and pass-all. The stimulus always raises sof_i together with a valid byte. It changes the enables only on byte cycles that the directed sampling tests pick, and applies random clears at any cycle, including the decision edge, so that set-over-clear is exercised. Random frames mix unicast, multicast, broadcast, station and near-station addresses with random idle gaps and abandoned partial addresses.

// File: rtl/rx_af_pkg.sv
package rx_af_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int CRC_W      = 32;
  localparam int CAUSE_W    = 6;

  // cause / enable bit positions
  localparam int C_UC  = 0;
  localparam int C_BC  = 1;
  localparam int C_MC  = 2;
  localparam int C_UCH = 3;
  localparam int C_MCH = 4;
  localparam int C_PF  = 5;

  // one nibble step; every feedback term uses the pre-step register value
  function automatic logic [CRC_W-1:0] crc_nibble(input logic [CRC_W-1:0] c,
                                                  input logic [3:0]       n,
                                                  input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] r;
    r = c << 4;
    for (int k = 0; k < 4; k++) begin
      if (c[28+k] ^ n[3-k]) r = r ^ (poly << k);
    end
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                input logic [7:0]       b,
                                                input logic [CRC_W-1:0] poly);
    return crc_nibble(crc_nibble(c, b[3:0], poly), b[7:4], poly);
  endfunction
endpackage

// File: rtl/rx_af_capture.sv
module rx_af_capture
  import rx_af_pkg::*;
#(
  parameter int NBYTES = ADDR_BYTES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sof_i,
  input  logic                byte_vld_i,
  input  logic [7:0]          byte_i,
  output logic                take_o,
  output logic                first_o,
  output logic                last_o,
  output logic [NBYTES*8-1:0] addr_o
);
  localparam int CNT_W = $clog2(NBYTES + 1);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(NBYTES);

  logic [CNT_W-1:0] cnt_q, cnt_d, idx;
  logic [7:0]       byte_q [NBYTES-1];

  always_comb begin
    idx     = sof_i ? '0 : cnt_q;
    take_o  = byte_vld_i & (sof_i | (cnt_q != IDLE));
    first_o = take_o & sof_i;
    last_o  = take_o & (idx == CNT_W'(NBYTES - 1));
    cnt_d   = take_o ? (idx + CNT_W'(1)) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= IDLE;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NBYTES - 1; g++) begin : g_byte
    logic wr;
    assign wr = take_o & (idx == CNT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  byte_q[g] <= '0;
      else if (wr) byte_q[g] <= byte_i;
    end
    assign addr_o[8*g +: 8] = byte_q[g];
  end
  // final byte goes straight from the input into the decision
  assign addr_o[8*(NBYTES-1) +: 8] = byte_i;
endmodule

// File: rtl/rx_af_crc.sv
module rx_af_crc
  import rx_af_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY     = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] INIT     = 32'hFFFF_FFFF,
  parameter int               HASH_LSB = 23,
  parameter int               HASH_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              first_i,
  input  logic [7:0]        byte_i,
  output logic [HASH_W-1:0] hash_idx_o
);
  logic [CRC_W-1:0] crc_q, crc_cur, crc_d;

  always_comb begin
    crc_cur    = first_i ? INIT : crc_q;
    crc_d      = crc_byte(crc_cur, byte_i, POLY);
    hash_idx_o = crc_d[HASH_LSB +: HASH_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= INIT;
    else if (take_i) crc_q <= crc_d;
  end
endmodule

// File: rtl/rx_af_decide.sv
module rx_af_decide
  import rx_af_pkg::*;
#(
  parameter int NBYTES = ADDR_BYTES,
  parameter int HASH_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 last_i,
  input  logic [NBYTES*8-1:0]  addr_i,
  input  logic [NBYTES*8-1:0]  station_i,
  input  logic [HASH_W-1:0]    hash_idx_i,
  input  logic [2**HASH_W-1:0] hash_tbl_i,
  input  logic [CAUSE_W-1:0]   filt_en_i,
  input  logic                 pass_all_i,
  input  logic [CAUSE_W-1:0]   wake_clr_i,
  output logic                 dec_vld_o,
  output logic                 accept_o,
  output logic                 bcast_o,
  output logic                 mcast_o,
  output logic [CAUSE_W-1:0]   cause_o,
  output logic [CAUSE_W-1:0]   wake_stat_o
);
  logic               is_mc, is_bc, hash_hit, stn_hit;
  logic [CAUSE_W-1:0] hit, cause_d, wake_d;
  logic               acc_d;

  always_comb begin
    is_mc    = addr_i[0];
    is_bc    = &addr_i;
    hash_hit = hash_tbl_i[hash_idx_i];
    stn_hit  = (addr_i == station_i);
    hit        = '0;
    hit[C_UC]  = ~is_mc;
    hit[C_BC]  = is_bc;
    hit[C_MC]  = is_mc;
    hit[C_UCH] = ~is_mc & hash_hit;
    hit[C_MCH] = is_mc & hash_hit;
    hit[C_PF]  = stn_hit;
    cause_d  = hit & filt_en_i;
    acc_d    = pass_all_i | (|cause_d);
    wake_d   = (wake_stat_o & ~wake_clr_i) | (last_i ? cause_d : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld_o   <= 1'b0;
      wake_stat_o <= '0;
    end else begin
      dec_vld_o   <= last_i;
      wake_stat_o <= wake_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_o <= 1'b0;
      bcast_o  <= 1'b0;
      mcast_o  <= 1'b0;
      cause_o  <= '0;
    end else if (last_i) begin
      accept_o <= acc_d;
      bcast_o  <= is_bc;
      mcast_o  <= is_mc;
      cause_o  <= cause_d;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_af_pkg::*;
#(
  parameter logic [31:0] CRC_POLY = 32'h04C1_1DB7,
  parameter logic [31:0] CRC_INIT = 32'hFFFF_FFFF,
  parameter int          HASH_LSB = 23,
  parameter int          HASH_W   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sof_i,
  input  logic                    byte_vld_i,
  input  logic [7:0]              byte_i,
  input  logic [CAUSE_W-1:0]      filt_en_i,
  input  logic                    pass_all_i,
  input  logic [15:0]             sta_w0_i,
  input  logic [15:0]             sta_w1_i,
  input  logic [15:0]             sta_w2_i,
  input  logic [2**(HASH_W-1)-1:0] hash_lo_i,
  input  logic [2**(HASH_W-1)-1:0] hash_hi_i,
  input  logic [CAUSE_W-1:0]      wake_clr_i,
  output logic                    dec_vld_o,
  output logic                    accept_o,
  output logic                    bcast_o,
  output logic                    mcast_o,
  output logic [CAUSE_W-1:0]      cause_o,
  output logic [CAUSE_W-1:0]      wake_stat_o
);
  localparam int AW = ADDR_BYTES * 8;

  logic              take, first, last;
  logic [AW-1:0]     addr, station;
  logic [HASH_W-1:0] hash_idx;

  // byte k of the station address sits at station[8k +: 8]
  assign station = {sta_w0_i, sta_w1_i, sta_w2_i};

  rx_af_capture #(.NBYTES(ADDR_BYTES)) u_cap (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .take_o(take), .first_o(first), .last_o(last),
    .addr_o(addr)
  );

  rx_af_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT), .HASH_LSB(HASH_LSB),
              .HASH_W(HASH_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .take_i(take), .first_i(first),
    .byte_i(byte_i), .hash_idx_o(hash_idx)
  );

  rx_af_decide #(.NBYTES(ADDR_BYTES), .HASH_W(HASH_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .last_i(last), .addr_i(addr),
    .station_i(station), .hash_idx_i(hash_idx),
    .hash_tbl_i({hash_hi_i, hash_lo_i}), .filt_en_i(filt_en_i),
    .pass_all_i(pass_all_i), .wake_clr_i(wake_clr_i),
    .dec_vld_o(dec_vld_o), .accept_o(accept_o), .bcast_o(bcast_o),
    .mcast_o(mcast_o), .cause_o(cause_o), .wake_stat_o(wake_stat_o)
  );
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk
  import rx_af_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               byte_vld_i,
  input logic [CAUSE_W-1:0] filt_en_i,
  input logic               pass_all_i,
  input logic [CAUSE_W-1:0] wake_clr_i,
  input logic               dec_vld_o,
  input logic               accept_o,
  input logic               bcast_o,
  input logic               mcast_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic [CAUSE_W-1:0] wake_stat_o
);
  logic [CAUSE_W-1:0] new_cause;
  assign new_cause = dec_vld_o ? cause_o : '0;

  // R3
  dec_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o |-> $past(byte_vld_i));
  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld_o |-> ($stable(accept_o) && $stable(cause_o) && $stable(mcast_o)));
  // R4
  bcast_is_mcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_o |-> mcast_o);
  // R7
  class_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o && mcast_o |-> !cause_o[C_UC] && !cause_o[C_UCH]);
  // R9
  cause_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o |-> ((cause_o & ~$past(filt_en_i)) == '0));
  // R9
  accept_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o && !$past(pass_all_i) |-> (accept_o == (cause_o != '0)));
  // R10
  pass_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o && $past(pass_all_i) |-> accept_o);
  // R11
  wake_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_stat_o & ~$past(wake_stat_o) & ~new_cause) == '0);
  // R11
  wake_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_stat_o & $past(wake_clr_i) & ~new_cause) == '0);
endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld_i(byte_vld_i), .filt_en_i(filt_en_i),
  .pass_all_i(pass_all_i), .wake_clr_i(wake_clr_i), .dec_vld_o(dec_vld_o),
  .accept_o(accept_o), .bcast_o(bcast_o), .mcast_o(mcast_o),
  .cause_o(cause_o), .wake_stat_o(wake_stat_o)
);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sof_i, byte_vld_i;
  logic [7:0]  byte_i;
  logic [5:0]  filt_en_i, wake_clr_i;
  logic        pass_all_i;
  logic [15:0] sta_w0_i, sta_w1_i, sta_w2_i;
  logic [31:0] hash_lo_i, hash_hi_i;
  logic        dec_vld_o, accept_o, bcast_o, mcast_o;
  logic [5:0]  cause_o, wake_stat_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [5:0]  ws_m;
  logic [47:0] sta;

  always #5 clk = ~clk;

  rx_addr_filter dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c, q;
    logic [3:0]  nb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++)
      for (int h = 0; h < 2; h++) begin
        nb = a[8*i + 4*h +: 4];
        q = 32'h0;
        if (c[28] ^ nb[3]) q ^= 32'h04C11DB7;
        if (c[29] ^ nb[2]) q ^= 32'h09823B6E;
        if (c[30] ^ nb[1]) q ^= 32'h130476DC;
        if (c[31] ^ nb[0]) q ^= 32'h2608EDB8;
        c = (c << 4) ^ q;
      end
    return c;
  endfunction

  function automatic logic ref_hash(input logic [47:0] a);
    logic [5:0] ix;
    ix = ref_crc(a)[28:23];
    return ix[5] ? hash_hi_i[ix[4:0]] : hash_lo_i[ix[4:0]];
  endfunction

  function automatic logic [5:0] ref_cause(input logic [47:0] a, input logic [5:0] en);
    logic mc, bc, hh;
    logic [5:0] c;
    mc = a[0]; bc = &a; hh = ref_hash(a);
    c[0] = !mc; c[1] = bc; c[2] = mc;
    c[3] = !mc && hh; c[4] = mc && hh; c[5] = (a == sta);
    return c & en;
  endfunction

  task automatic set_station(input logic [47:0] s);
    sta = s;
    sta_w2_i = s[15:0]; sta_w1_i = s[31:16]; sta_w0_i = s[47:32];
  endtask

  // drive one cycle from a negedge, advance to the next negedge
  task automatic tick(input logic v, input logic s, input logic [7:0] b,
                      input logic [5:0] clr, input logic lst, input logic [5:0] cz);
    byte_vld_i = v; sof_i = s; byte_i = b; wake_clr_i = clr;
    @(negedge clk);
    ws_m = (ws_m & ~clr) | (lst ? cz : 6'h0);
  endtask

  task automatic idle();
    tick(1'b0, 1'b0, 8'h00, 6'h0, 1'b0, 6'h0);
  endtask

  // sends six bytes, optional random gaps and clears, then checks the decision
  task automatic send_check(input logic [47:0] a, input logic gaps, input logic clrs, input string tag);
    logic [5:0] cz, clr;
    logic       acc;
    cz  = ref_cause(a, filt_en_i);
    acc = pass_all_i || (cz != 6'h0);
    for (int i = 0; i < 6; i++) begin
      if (gaps && ($urandom_range(0, 3) == 0)) begin
        clr = clrs ? 6'($urandom) & 6'($urandom) : 6'h0;
        tick(1'b0, 1'b0, 8'h00, clr, 1'b0, 6'h0);
      end
      clr = clrs ? 6'($urandom) & 6'($urandom) : 6'h0;
      tick(1'b1, i == 0, a[8*i +: 8], clr, i == 5, cz);
    end
    check({tag, " R3 dec_vld"}, dec_vld_o, 1);
    check({tag, " R9/R10 accept"}, accept_o, acc);
    check({tag, " R4 bcast"}, bcast_o, &a);
    check({tag, " R4 mcast"}, mcast_o, a[0]);
    check({tag, " R9 cause"}, cause_o, cz);
    check({tag, " R11 wake"}, wake_stat_o, ws_m);
    idle();
    check({tag, " R3 pulse"}, dec_vld_o, 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] a;
    logic [5:0]  ix;
    logic        acc_hold;
    void'($urandom(32'h5EED_0042));
    ws_m = 6'h0;
    rst_n = 1'b0; sof_i = 0; byte_vld_i = 0; byte_i = 0; wake_clr_i = 0;
    filt_en_i = 0; pass_all_i = 0; hash_lo_i = 0; hash_hi_i = 0;
    set_station(48'h5544_3322_1100);
    repeat (3) @(negedge clk);
    check("R1 reset outs", {dec_vld_o, accept_o, bcast_o, mcast_o, cause_o, wake_stat_o}, 0);
    rst_n = 1'b1;
    idle();
    check("R1 after release", {dec_vld_o, accept_o, bcast_o, mcast_o, cause_o, wake_stat_o}, 0);

    // R6 broadcast only
    filt_en_i = 6'b000010;
    send_check(48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, "R6 bc");
    // R5 station match and mismatch in last byte
    filt_en_i = 6'b100000;
    send_check(48'h5544_3322_1100, 1'b0, 1'b0, "R5 hit");
    send_check(48'h5444_3322_1100, 1'b0, 1'b0, "R5 miss");
    // R7 all-unicast / all-multicast
    filt_en_i = 6'b000001;
    send_check(48'h0A0B_0C0D_0E02, 1'b1, 1'b0, "R7 uc");
    send_check(48'h0A0B_0C0D_0E03, 1'b1, 1'b0, "R7 mc-rej");
    filt_en_i = 6'b000100;
    send_check(48'h0A0B_0C0D_0E03, 1'b0, 1'b0, "R7 mc");
    // R8 hash: single selected entry set, then all but it
    a = 48'h1234_5678_9ABC;
    ix = ref_crc(a)[28:23];
    filt_en_i = 6'b001000;
    {hash_hi_i, hash_lo_i} = 64'h1 << ix;
    send_check(a, 1'b0, 1'b0, "R8 uc hash hit");
    check("R8 hash accept", accept_o, 1);
    {hash_hi_i, hash_lo_i} = ~(64'h1 << ix);
    send_check(a, 1'b0, 1'b0, "R8 uc hash miss");
    check("R8 hash reject", accept_o, 0);
    a = 48'h0102_0304_0501;
    ix = ref_crc(a)[28:23];
    filt_en_i = 6'b010000;
    {hash_hi_i, hash_lo_i} = 64'h1 << ix;
    send_check(a, 1'b0, 1'b0, "R8 mc hash hit");
    // R10 pass-all with no enables
    filt_en_i = 6'b0; pass_all_i = 1'b1;
    send_check(48'h0A0B_0C0D_0E02, 1'b0, 1'b0, "R10");
    pass_all_i = 1'b0;
    // R2 bytes after the sixth are ignored
    acc_hold = accept_o;
    for (int i = 0; i < 4; i++) begin
      tick(1'b1, 1'b0, 8'hFF, 6'h0, 1'b0, 6'h0);
      check("R2 no extra dec", dec_vld_o, 0);
    end
    check("R3 hold accept", accept_o, acc_hold);
    // R2 sof restarts a partial address
    filt_en_i = 6'b100000;
    tick(1'b1, 1'b1, 8'hEE, 6'h0, 1'b0, 6'h0);
    tick(1'b1, 1'b0, 8'hEE, 6'h0, 1'b0, 6'h0);
    tick(1'b1, 1'b0, 8'hEE, 6'h0, 1'b0, 6'h0);
    send_check(48'h5544_3322_1100, 1'b0, 1'b0, "R2 restart");
    // R11 clear, then set-wins-over-clear
    tick(1'b0, 1'b0, 8'h00, 6'b100000, 1'b0, 6'h0);
    check("R11 cleared", wake_stat_o, ws_m);
    check("R11 cleared bit", wake_stat_o[5], 0);
    for (int i = 0; i < 6; i++)
      tick(1'b1, i == 0, sta[8*i +: 8], i == 5 ? 6'b100000 : 6'h0, i == 5, 6'b100000);
    check("R11 set wins", wake_stat_o[5], 1);
    idle();
    // R12 enables sampled only on the final byte
    for (int i = 0; i < 6; i++) begin
      filt_en_i = (i == 5) ? 6'b100000 : 6'b000000;
      tick(1'b1, i == 0, sta[8*i +: 8], 6'h0, i == 5, 6'b100000);
    end
    check("R12 late enable", accept_o, 1);
    for (int i = 0; i < 6; i++) begin
      filt_en_i = (i == 5) ? 6'b000000 : 6'b111111;
      pass_all_i = (i != 5);
      tick(1'b1, i == 0, sta[8*i +: 8], 6'h0, i == 5, 6'h0);
    end
    check("R12 early enable ignored", accept_o, 0);
    pass_all_i = 1'b0;
    idle();

    // random mix
    for (int n = 0; n < 400; n++) begin
      int kind;
      if (n % 50 == 0) set_station({$urandom, $urandom} & 48'hFFFF_FFFF_FFFE);
      hash_lo_i = $urandom; hash_hi_i = $urandom;
      filt_en_i = 6'($urandom);
      pass_all_i = ($urandom_range(0, 7) == 0);
      kind = $urandom_range(0, 4);
      case (kind)
        0: a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFE;
        1: a = {$urandom, $urandom} | 48'h1;
        2: a = 48'hFFFF_FFFF_FFFF;
        3: a = sta;
        default: a = sta ^ (48'h1 << $urandom_range(1, 47));
      endcase
      if ($urandom_range(0, 9) == 0) begin
        tick(1'b1, 1'b1, 8'($urandom), 6'h0, 1'b0, 6'h0);
        tick(1'b1, 1'b0, 8'($urandom), 6'h0, 1'b0, 6'h0);
      end
      send_check(a, 1'b1, 1'b1, "rand R2/R4/R5/R6/R7/R8");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule